// File: doc/BRIEF.md
# PLL Power-Up and Lock Sequencer

This block orders the steps that bring a PLL and its clock outputs up and take them down again. On a prepare request it enables the bias and then the system muxes of the local instance, lets them settle, repeats the same for a partner instance when dual-link operation is selected, starts the local PLL and polls a lock status word on a microsecond tick until lock is seen or a timeout expires. After lock it opens the global clock gates and then the output buffers, first on the local instance and then on the partner.

On an unprepare request it reverses the order in a glitch-safe way: the clock gate closes before the PLL stops, and power is removed last. The partner's teardown follows the local one. A one-cycle done pulse closes every sequence, and a sticky failure flag reports a missing lock. The settle waits are counted in system-clock cycles, and the poll interval and the timeout are counted in microsecond ticks. All three are parameters.

Top module: `pll_pwr_seq`

## Requirements
- R1: While reset is held, and after it, every enable output, `pll_on`, `seq_done` and `lock_fail` is 0.
- R2: A prepare sets the local bias one cycle after acceptance and the local mux the cycle after that. It then waits SETTLE_CYC+1 cycles. With a partner present, the partner's bias and mux follow in the same pattern, with their own wait.
- R3: `pll_start` rises only on the local instance, one cycle after the last settle wait, and only while the local bias and mux are on.
- R4: Lock is taken from bit 0 of `lock_stat`, and the upper bits are ignored. The first sample is one cycle after `pll_start` rises, and each later sample comes once POLL_US ticks have accumulated since the previous one.
- R5: If a sample shows no lock once TIMEOUT_US ticks have elapsed, `lock_fail` is set and `seq_done` pulses. Gates and buffers stay off. `lock_fail` holds until the next prepare is accepted.
- R6: One cycle after the lock sample, `pll_on` and the local global clock enable rise together. They are followed, one per cycle, by the partner clock enable (if a partner is present), the local buffer enable, the partner buffer enable (if a partner is present), and then `seq_done`.
- R7: An unprepare clears, one per cycle, the local clock enable, `pll_start`, the local buffer, the local mux and the local bias, and then waits SETTLE_CYC+1 cycles.
- R8: With a partner, its clock enable, buffer, mux and bias are then cleared one per cycle, followed by its own wait. After that `pll_on` clears and `seq_done` pulses in the same cycle.
- R9: Requests that arrive while a sequence runs are ignored, and `slave_present` is captured when a request is accepted.
- R10: `seq_done` lasts exactly one cycle. When prepare and unprepare arrive together at an idle block, prepare wins.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| prep_req | input | 1 | Request to power up and lock |
| unprep_req | input | 1 | Request to power down |
| slave_present | input | 1 | A partner instance takes part in the sequence |
| lock_stat | input | STAT_W | PLL status word; bit 0 is lock |
| us_tick | input | 1 | One-cycle pulse per microsecond |
| bias_en | output | 2 | Bias enable, [0] local, [1] partner |
| mux_en | output | 2 | System mux enable, [0] local, [1] partner |
| pll_start | output | 1 | Local PLL start |
| gclk_en | output | 2 | Global clock gate enable, [0] local, [1] partner |
| obuf_en | output | 2 | Output buffer enable, [0] local, [1] partner |
| seq_done | output | 1 | One-cycle end-of-sequence pulse |
| pll_on | output | 1 | PLL is locked and running |
| lock_fail | output | 1 | Lock was not seen before the timeout |

## Verification
Every output is a register, so each step appears one cycle after the edge that accepted it. The only exceptions are the settle waits, which add SETTLE_CYC+1 cycles, and the poll phase, whose length depends on when ticks and lock arrive. The bench's reference model walks through the same ordering with its own tick and lock bookkeeping and sets its expected values at each rising edge. All outputs are compared at the following falling edge, so every result is checked in the exact cycle it is due.

// File: rtl/pll_seq_pkg.sv
package pll_seq_pkg;

  typedef enum logic [4:0] {
    ST_IDLE,
    ST_U_BIAS_L, ST_U_MUX_L, ST_U_WAIT_L,
    ST_U_BIAS_S, ST_U_MUX_S, ST_U_WAIT_S,
    ST_U_START, ST_U_POLL, ST_U_GCLK_S,
    ST_U_BUF_L, ST_U_BUF_S, ST_U_DONE,
    ST_D_GCLK_L, ST_D_STOP, ST_D_BUF_L, ST_D_MUX_L, ST_D_BIAS_L, ST_D_WAIT_L,
    ST_D_GCLK_S, ST_D_BUF_S, ST_D_MUX_S, ST_D_BIAS_S, ST_D_WAIT_S,
    ST_D_END
  } seq_state_e;

  // A sample is due on the first cycle of polling or once the interval is reached.
  function automatic logic sample_due(input logic first_s,
                                      input int unsigned ivl_next,
                                      input int unsigned period);
    return first_s || (ivl_next >= period);
  endfunction

  // Timeout has expired once the elapsed tick count reaches the limit.
  function automatic logic time_up(input int unsigned elapsed,
                                   input int unsigned limit);
    return elapsed >= limit;
  endfunction

endpackage

// File: rtl/pll_settle_timer.sv
module pll_settle_timer #(
  parameter int SETTLE_CYC = 50
) (
  input  logic clk,
  input  logic rst_n,
  input  logic go,
  output logic zero
);
  localparam int CW = $clog2(SETTLE_CYC + 1);

  logic [CW-1:0] cnt;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt <= '0;
    end else if (go) begin
      cnt <= CW'(SETTLE_CYC);
    end else if (cnt != '0) begin
      cnt <= cnt - 1'b1;
    end
  end

  assign zero = (cnt == '0);

endmodule

// File: rtl/pll_lock_poller.sv
module pll_lock_poller
  import pll_seq_pkg::*;
#(
  parameter int POLL_US    = 100,
  parameter int TIMEOUT_US = 5000
) (
  input  logic clk,
  input  logic rst_n,
  input  logic go,
  input  logic tick,
  input  logic lock_bit,
  output logic hit,
  output logic miss
);
  localparam int IW = $clog2(POLL_US + 1) + 1;
  localparam int EW = $clog2(TIMEOUT_US + 1) + 1;

  logic          active;
  logic          first_s;
  logic [IW-1:0] ivl;
  logic [EW-1:0] el;
  logic [IW-1:0] ivl_nxt;
  logic [EW-1:0] el_nxt;
  logic          due;
  logic          expired;

  assign ivl_nxt = ivl + IW'(tick);
  assign el_nxt  = (el >= EW'(TIMEOUT_US)) ? el : el + EW'(tick);
  assign due     = sample_due(first_s, 32'(ivl_nxt), 32'(POLL_US));
  assign expired = time_up(32'(el_nxt), 32'(TIMEOUT_US));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      active  <= 1'b0;
      first_s <= 1'b0;
      ivl     <= '0;
      el      <= '0;
      hit     <= 1'b0;
      miss    <= 1'b0;
    end else begin
      hit  <= 1'b0;
      miss <= 1'b0;
      if (go) begin
        active  <= 1'b1;
        first_s <= 1'b1;
        ivl     <= '0;
        el      <= '0;
      end else if (active) begin
        first_s <= 1'b0;
        el      <= el_nxt;
        if (due) begin
          ivl <= '0;
          if (lock_bit) begin
            hit    <= 1'b1;
            active <= 1'b0;
          end else if (expired) begin
            miss   <= 1'b1;
            active <= 1'b0;
          end
        end else begin
          ivl <= ivl_nxt;
        end
      end
    end
  end

  p_result_from_active_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (hit || miss) |-> $past(active));
  p_miss_needs_time_r5: assert property (@(posedge clk) disable iff (!rst_n)
    miss |-> !$past(first_s) || (TIMEOUT_US == 0));

endmodule

// File: rtl/pll_pwr_seq.sv
module pll_pwr_seq
  import pll_seq_pkg::*;
#(
  parameter int SETTLE_CYC = 50,
  parameter int POLL_US    = 100,
  parameter int TIMEOUT_US = 5000,
  parameter int STAT_W     = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              prep_req,
  input  logic              unprep_req,
  input  logic              slave_present,
  input  logic [STAT_W-1:0] lock_stat,
  input  logic              us_tick,
  output logic [1:0]        bias_en,
  output logic [1:0]        mux_en,
  output logic              pll_start,
  output logic [1:0]        gclk_en,
  output logic [1:0]        obuf_en,
  output logic              seq_done,
  output logic              pll_on,
  output logic              lock_fail
);
  localparam int LOC = 0;
  localparam int SLV = 1;

  seq_state_e st;
  logic       slv_q;
  logic       tmr_go;
  logic       tmr_zero;
  logic       poll_go;
  logic       lock_hit;
  logic       lock_miss;
  logic       up_accept;
  logic       dn_accept;
  logic       idle_s;

  assign idle_s    = (st == ST_IDLE);
  assign up_accept = idle_s && prep_req;
  assign dn_accept = idle_s && !prep_req && unprep_req;
  assign tmr_go    = (st == ST_U_MUX_L) || (st == ST_U_MUX_S) ||
                     (st == ST_D_BIAS_L) || (st == ST_D_BIAS_S);
  assign poll_go   = (st == ST_U_START);

  pll_settle_timer #(.SETTLE_CYC(SETTLE_CYC)) u_tmr (
    .clk  (clk),
    .rst_n(rst_n),
    .go   (tmr_go),
    .zero (tmr_zero)
  );

  pll_lock_poller #(.POLL_US(POLL_US), .TIMEOUT_US(TIMEOUT_US)) u_poll (
    .clk     (clk),
    .rst_n   (rst_n),
    .go      (poll_go),
    .tick    (us_tick),
    .lock_bit(lock_stat[0]),
    .hit     (lock_hit),
    .miss    (lock_miss)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st        <= ST_IDLE;
      slv_q     <= 1'b0;
      bias_en   <= '0;
      mux_en    <= '0;
      pll_start <= 1'b0;
      gclk_en   <= '0;
      obuf_en   <= '0;
      seq_done  <= 1'b0;
      pll_on    <= 1'b0;
      lock_fail <= 1'b0;
    end else begin
      seq_done <= 1'b0;
      case (st)
        ST_IDLE: begin
          if (up_accept) begin
            slv_q     <= slave_present;
            lock_fail <= 1'b0;
            st        <= ST_U_BIAS_L;
          end else if (dn_accept) begin
            slv_q <= slave_present;
            st    <= ST_D_GCLK_L;
          end
        end
        ST_U_BIAS_L: begin bias_en[LOC] <= 1'b1; st <= ST_U_MUX_L; end
        ST_U_MUX_L:  begin mux_en[LOC]  <= 1'b1; st <= ST_U_WAIT_L; end
        ST_U_WAIT_L: if (tmr_zero) st <= slv_q ? ST_U_BIAS_S : ST_U_START;
        ST_U_BIAS_S: begin bias_en[SLV] <= 1'b1; st <= ST_U_MUX_S; end
        ST_U_MUX_S:  begin mux_en[SLV]  <= 1'b1; st <= ST_U_WAIT_S; end
        ST_U_WAIT_S: if (tmr_zero) st <= ST_U_START;
        ST_U_START:  begin pll_start <= 1'b1; st <= ST_U_POLL; end
        ST_U_POLL: begin
          if (lock_hit) begin
            pll_on       <= 1'b1;
            gclk_en[LOC] <= 1'b1;
            st           <= slv_q ? ST_U_GCLK_S : ST_U_BUF_L;
          end else if (lock_miss) begin
            lock_fail <= 1'b1;
            seq_done  <= 1'b1;
            st        <= ST_IDLE;
          end
        end
        ST_U_GCLK_S: begin gclk_en[SLV] <= 1'b1; st <= ST_U_BUF_L; end
        ST_U_BUF_L: begin
          obuf_en[LOC] <= 1'b1;
          st           <= slv_q ? ST_U_BUF_S : ST_U_DONE;
        end
        ST_U_BUF_S:  begin obuf_en[SLV] <= 1'b1; st <= ST_U_DONE; end
        ST_U_DONE:   begin seq_done <= 1'b1; st <= ST_IDLE; end
        ST_D_GCLK_L: begin gclk_en[LOC] <= 1'b0; st <= ST_D_STOP; end
        ST_D_STOP:   begin pll_start    <= 1'b0; st <= ST_D_BUF_L; end
        ST_D_BUF_L:  begin obuf_en[LOC] <= 1'b0; st <= ST_D_MUX_L; end
        ST_D_MUX_L:  begin mux_en[LOC]  <= 1'b0; st <= ST_D_BIAS_L; end
        ST_D_BIAS_L: begin bias_en[LOC] <= 1'b0; st <= ST_D_WAIT_L; end
        ST_D_WAIT_L: if (tmr_zero) st <= slv_q ? ST_D_GCLK_S : ST_D_END;
        ST_D_GCLK_S: begin gclk_en[SLV] <= 1'b0; st <= ST_D_BUF_S; end
        ST_D_BUF_S:  begin obuf_en[SLV] <= 1'b0; st <= ST_D_MUX_S; end
        ST_D_MUX_S:  begin mux_en[SLV]  <= 1'b0; st <= ST_D_BIAS_S; end
        ST_D_BIAS_S: begin bias_en[SLV] <= 1'b0; st <= ST_D_WAIT_S; end
        ST_D_WAIT_S: if (tmr_zero) st <= ST_D_END;
        ST_D_END: begin
          pll_on   <= 1'b0;
          seq_done <= 1'b1;
          st       <= ST_IDLE;
        end
        default: st <= ST_IDLE;
      endcase
    end
  end

  p_start_powered_r3: assert property (@(posedge clk) disable iff (!rst_n)
    pll_start |-> (bias_en[LOC] && mux_en[LOC]));
  p_on_after_start_r4: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(pll_on) |-> $past(pll_start));
  p_fail_gated_r5: assert property (@(posedge clk) disable iff (!rst_n)
    lock_fail |-> (gclk_en == 2'b00) && (obuf_en == 2'b00));
  p_gate_before_stop_r7: assert property (@(posedge clk) disable iff (!rst_n)
    gclk_en[LOC] |-> pll_start);
  p_buf_needs_on_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (obuf_en != 2'b00) |-> pll_on);
  p_slave_gate_up_r6: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(gclk_en[SLV]) |-> gclk_en[LOC]);
  p_slave_gate_down_r8: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(gclk_en[SLV]) |-> !gclk_en[LOC] && !pll_start);
  p_slave_bias_order_r2: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(bias_en[SLV]) |-> mux_en[LOC]);
  p_done_pulse_r10: assert property (@(posedge clk) disable iff (!rst_n)
    seq_done |=> !seq_done);

endmodule

// File: tb/sim_pll_pwr_seq.sv
module sim_pll_pwr_seq;
  localparam int SET = 3;
  localparam int PER = 4;
  localparam int TMO = 20;
  localparam int SW  = 8;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          prep_req = 1'b0;
  logic          unprep_req = 1'b0;
  logic          slave_present = 1'b0;
  logic [SW-1:0] lock_stat = '0;
  logic          us_tick = 1'b0;
  logic [1:0]    bias_en, mux_en, gclk_en, obuf_en;
  logic          pll_start, seq_done, pll_on, lock_fail;

  always #2.5 clk = ~clk;

  pll_pwr_seq #(.SETTLE_CYC(SET), .POLL_US(PER), .TIMEOUT_US(TMO), .STAT_W(SW)) u0 (
    .clk(clk), .rst_n(rst_n), .prep_req(prep_req), .unprep_req(unprep_req),
    .slave_present(slave_present), .lock_stat(lock_stat), .us_tick(us_tick),
    .bias_en(bias_en), .mux_en(mux_en), .pll_start(pll_start), .gclk_en(gclk_en),
    .obuf_en(obuf_en), .seq_done(seq_done), .pll_on(pll_on), .lock_fail(lock_fail)
  );

  int checks = 0;
  int errors = 0;
  int cyc = 0;
  int tick_ctr = 0;
  int lk_cnt = 0;
  int lk_after = 0;

  // Expected outputs from the reference model
  logic [1:0] x_bias = 0, x_mux = 0, x_gclk = 0, x_obuf = 0;
  logic       x_start = 0, x_done = 0, x_on = 0, x_fail = 0;
  bit         model_run = 0;

  // Tick source and lock stub: lock appears lk_after ticks after start; upper bits are noise
  always @(negedge clk) begin
    cyc++;
    tick_ctr++;
    us_tick = (tick_ctr % 3 == 0);
    if (!pll_start) lk_cnt = 0;
    else if (us_tick) lk_cnt++;
    lock_stat = {7'b1011011, (pll_start && lk_cnt >= lk_after)};
  end

  task automatic chk(input logic [1:0] act, input logic [1:0] exp, input string tag);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s at cycle %0d: actual %b expected %b", tag, cyc, act, exp);
    end
  endtask

  always @(negedge clk) begin
    if (model_run) begin
      chk(bias_en, x_bias, "R2 R7 R8 bias");
      chk(mux_en, x_mux, "R2 R7 R8 mux");
      chk({1'b0, pll_start}, {1'b0, x_start}, "R3 start");
      chk(gclk_en, x_gclk, "R6 R7 gclk");
      chk(obuf_en, x_obuf, "R6 R8 obuf");
      chk({1'b0, seq_done}, {1'b0, x_done}, "R10 done");
      chk({1'b0, pll_on}, {1'b0, x_on}, "R6 on");
      chk({1'b0, lock_fail}, {1'b0, x_fail}, "R5 fail");
    end
  end

  task automatic m_step();
    @(posedge clk);
    x_done = 1'b0;
  endtask

  task automatic m_up(input bit s);
    int ivl = 0;
    int el = 0;
    bit first = 1;
    bit got = 0;
    x_fail = 0;
    m_step(); x_bias[0] = 1;
    m_step(); x_mux[0] = 1;
    repeat (SET + 1) m_step();
    if (s) begin
      m_step(); x_bias[1] = 1;
      m_step(); x_mux[1] = 1;
      repeat (SET + 1) m_step();
    end
    m_step(); x_start = 1;
    forever begin
      m_step();
      begin
        int ivn = ivl + (us_tick ? 1 : 0);
        int eln = (el >= TMO) ? el : el + (us_tick ? 1 : 0);
        el = eln;
        if (first || ivn >= PER) begin
          ivl = 0;
          if (lock_stat[0]) begin got = 1; break; end
          if (eln >= TMO) break;
        end else ivl = ivn;
        first = 0;
      end
    end
    m_step();
    if (!got) begin
      x_fail = 1; x_done = 1;
      return;
    end
    x_on = 1; x_gclk[0] = 1;
    if (s) begin m_step(); x_gclk[1] = 1; end
    m_step(); x_obuf[0] = 1;
    if (s) begin m_step(); x_obuf[1] = 1; end
    m_step(); x_done = 1;
  endtask

  task automatic m_down(input bit s);
    m_step(); x_gclk[0] = 0;
    m_step(); x_start = 0;
    m_step(); x_obuf[0] = 0;
    m_step(); x_mux[0] = 0;
    m_step(); x_bias[0] = 0;
    repeat (SET + 1) m_step();
    if (s) begin
      m_step(); x_gclk[1] = 0;
      m_step(); x_obuf[1] = 0;
      m_step(); x_mux[1] = 0;
      m_step(); x_bias[1] = 0;
      repeat (SET + 1) m_step();
    end
    m_step(); x_on = 0; x_done = 1;
  endtask

  initial begin
    wait (model_run);
    forever begin
      m_step();
      if (prep_req) m_up(slave_present);
      else if (unprep_req) m_down(slave_present);
    end
  end

  task automatic pulse(input bit p, input bit u);
    @(negedge clk);
    prep_req = p; unprep_req = u;
    @(negedge clk);
    prep_req = 0; unprep_req = 0;
  endtask

  task automatic wait_done();
    for (int i = 0; i < 3000; i++) begin
      @(negedge clk);
      if (seq_done) return;
    end
    errors++;
    $display("FAIL R10 no done: actual 0 expected 1");
  endtask

  task automatic named(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
    end
  endtask

  initial begin
    repeat (4) @(negedge clk);
    named({bias_en, mux_en, pll_start, gclk_en, obuf_en, seq_done, pll_on, lock_fail} == '0,
          "R1 reset outputs", int'(bias_en), 0);
    rst_n = 1;
    model_run = 1;
    // Partner absent, lock after 5 ticks; an unprepare mid-sequence is ignored
    slave_present = 0; lk_after = 5;
    pulse(1, 0);
    repeat (3) @(negedge clk);
    pulse(0, 1);
    wait_done();
    named(pll_on && obuf_en == 2'b01, "R4 R9 locked local", int'(obuf_en), 1);
    pulse(0, 0);
    pulse(0, 1);
    wait_done();
    named(bias_en == 0 && mux_en == 0 && !pll_on, "R7 down local", int'(bias_en), 0);
    // Partner present, immediate lock; partner flag drops mid-sequence
    slave_present = 1; lk_after = 0;
    pulse(1, 0);
    repeat (2) @(negedge clk);
    slave_present = 0;
    wait_done();
    named(obuf_en == 2'b11 && gclk_en == 2'b11, "R6 R9 both outputs", int'(obuf_en), 3);
    slave_present = 1;
    pulse(0, 1);
    wait_done();
    named(bias_en == 0 && mux_en == 0 && gclk_en == 0, "R8 down both", int'(bias_en), 0);
    // Lock never arrives
    lk_after = 100000;
    pulse(1, 0);
    wait_done();
    named(lock_fail && gclk_en == 0 && obuf_en == 0, "R5 timeout", int'(lock_fail), 1);
    pulse(0, 1);
    wait_done();
    named(lock_fail && bias_en == 0, "R5 flag held", int'(lock_fail), 1);
    // Simultaneous requests: prepare wins
    slave_present = 0; lk_after = 2;
    pulse(1, 1);
    wait_done();
    named(pll_on && !lock_fail, "R10 prepare priority", int'(pll_on), 1);
    @(negedge clk);
    named(!seq_done, "R10 done one cycle", int'(seq_done), 0);
    pulse(0, 1);
    wait_done();
    repeat (3) @(negedge clk);
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    #(5.0 * 150000);
    errors++;
    $display("FAIL watchdog: actual hung expected finish");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule